// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

This block takes up to 32 level-sensitive peripheral interrupt lines and routes each one onto one of seven core priority request outputs, numbered 7 to 13. A source counts as pending when its status bit is set and its mask bit is set. Each source has its own 4-bit routing field. Only field values 0 to 6 select an output; any larger value routes the source nowhere. A small register bus holds the routing fields, the mask, the status and a spurious-event count.

When a core level fires, the interrupt handler asks the lookup port which source caused it. The lookup returns the lowest-numbered pending source that is routed to that level. If no such source exists, it raises a spurious flag and increments a saturating counter. The lookup is a three-state machine: `LK_IDLE` waits for a start, `LK_SCAN` evaluates the chosen level and registers the result, and `LK_DONE` presents the result for one cycle. The transitions are `LK_IDLE -> LK_SCAN` on start, `LK_SCAN -> LK_DONE` always, and `LK_DONE -> LK_IDLE` always.

Top module: `periph_irq_router`

## Requirements
- R1: The status register samples `irq_in` through one register stage. The bus reads it at address 5, with bit n belonging to source n.
- R2: After reset, the mask (address 4) reads all ones, every routing register reads 0xFFFFFFFF (all sources unrouted), the spurious count reads 0, `lvl_req` is 0 and `lk_done` is 0.
- R3: Routing registers sit at addresses 0 to 3. The field of source n is in register n>>3, at bits (n&7)*4 to (n&7)*4+3. A field value v from 0 to 6 routes the source to `lvl_req[v]`, which is core level 7+v.
- R4: A field value from 7 to 15 routes its source to no output.
- R5: A source is pending only when both its status bit and its mask bit (address 4, bit n) are 1. A masked source drives no output.
- R6: `lvl_req[v]` is the OR of all pending sources whose field equals v. It reflects an `irq_in` change or a bus write on the cycle after the capturing clock edge.
- R7: A `lk_start` accepted in `LK_IDLE` samples `lk_level` (0 to 6 select core levels 7 to 13). Two edges later, `lk_done` is high for exactly one cycle. At that time `lk_src` gives the lowest-numbered source that is pending and routed to that level.
- R8: When no source qualifies, `lk_spurious` is high together with `lk_done`, and the spurious count increases by one. A lookup that finds a source leaves the count unchanged.
- R9: The spurious count is CNT_W bits wide (16 by default), stops at its maximum and reads at address 6.
- R10: The design ignores each of the following:
  - Writes to addresses 5 and 6.
  - A `lk_start` that arrives while the machine is busy.
  - A `lk_level` value of 7, which always reports spurious.
  
  Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Peripheral request lines, level sensitive |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| lvl_req | output | 7 | Request per core level 7..13 (bit v = level 7+v) |
| lk_start | input | 1 | Start a source lookup |
| lk_level | input | 3 | Level to look up (v selects level 7+v) |
| lk_done | output | 1 | Lookup result valid, one cycle |
| lk_spurious | output | 1 | Lookup found no pending source |
| lk_src | output | SRC_W | Lowest pending source at the level |

## Verification
An `irq_in` change or a mask or routing write is captured on one edge. The resulting `lvl_req` and status readback are checked at the next falling edge. A lookup start is driven at a falling edge, accepted on the following rising edge and registered on the rising edge after that. The bench therefore samples `lk_done`, `lk_src` and the spurious count two falling edges after it raises start, and checks one falling edge later that `lk_done` has dropped. Bus reads are combinational, so they are sampled shortly after the address is set, well clear of any edge.

// File: rtl/pir_pkg.sv
package pir_pkg;
    localparam int FIELD_W  = 4;
    localparam int NUM_LVL  = 7;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = 32;
    localparam int PER_REG  = DATA_W / FIELD_W;

    localparam logic [ADDR_W-1:0] ADR_MASK = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_STAT = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_SPUR = 3'd6;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_SCAN = 2'd1,
        LK_DONE = 2'd2
    } lk_state_e;
endpackage

// File: rtl/pir_regs.sv
module pir_regs
    import pir_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_en,
    input  logic                              bus_we,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [DATA_W-1:0]                 bus_wdata,
    output logic [DATA_W-1:0]                 bus_rdata,
    input  logic [NUM_SRC-1:0]                irq_in,
    input  logic [CNT_W-1:0]                  spur_cnt,
    output logic [NUM_SRC-1:0][FIELD_W-1:0]   route_o,
    output logic [NUM_SRC-1:0]                mask_o,
    output logic [NUM_SRC-1:0]                status_o
);
    localparam int NUM_REG = NUM_SRC / PER_REG;

    logic [NUM_SRC-1:0][FIELD_W-1:0] route_q;
    logic [NUM_SRC-1:0]              mask_q;
    logic [NUM_SRC-1:0]              status_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q  <= '1;
            mask_q   <= '1;
            status_q <= '0;
        end else begin
            status_q <= irq_in;
            if (bus_en && bus_we) begin
                if (bus_addr == ADR_MASK)
                    mask_q <= bus_wdata[NUM_SRC-1:0];
                for (int r = 0; r < NUM_REG; r++) begin
                    if (bus_addr == ADDR_W'(r))
                        route_q[r*PER_REG +: PER_REG] <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADR_MASK: bus_rdata[NUM_SRC-1:0] = mask_q;
            ADR_STAT: bus_rdata[NUM_SRC-1:0] = status_q;
            ADR_SPUR: bus_rdata[CNT_W-1:0]   = spur_cnt;
            default: begin
                for (int r = 0; r < NUM_REG; r++) begin
                    if (bus_addr == ADDR_W'(r))
                        bus_rdata = route_q[r*PER_REG +: PER_REG];
                end
            end
        endcase
    end

    assign route_o  = route_q;
    assign mask_o   = mask_q;
    assign status_o = status_q;
endmodule

// File: rtl/pir_level_map.sv
module pir_level_map
    import pir_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0][FIELD_W-1:0] route,
    input  logic [NUM_SRC-1:0]              pend,
    output logic [NUM_LVL-1:0]              lvl_req
);
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        logic any_hit;
        always_comb begin
            any_hit = 1'b0;
            for (int n = 0; n < NUM_SRC; n++) begin
                if (pend[n] && (route[n] == FIELD_W'(l)))
                    any_hit = 1'b1;
            end
        end
        assign lvl_req[l] = any_hit;
    end
endmodule

// File: rtl/pir_lookup.sv
module pir_lookup
    import pir_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 16,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            lk_start,
    input  logic [2:0]                      lk_level,
    input  logic [NUM_SRC-1:0][FIELD_W-1:0] route,
    input  logic [NUM_SRC-1:0]              pend,
    output logic                            lk_done,
    output logic                            lk_spurious,
    output logic [SRC_W-1:0]                lk_src,
    output logic [CNT_W-1:0]                spur_cnt
);
    lk_state_e          state_q, state_d;
    logic [2:0]         level_q;
    logic [SRC_W-1:0]   src_q;
    logic               spur_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_SRC-1:0] hit;
    logic               found;
    logic [SRC_W-1:0]   found_idx;
    logic               level_ok;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_IDLE: if (lk_start) state_d = LK_SCAN;
            LK_SCAN: state_d = LK_DONE;
            LK_DONE: state_d = LK_IDLE;
            default: state_d = LK_IDLE;
        endcase
    end

    // level compare and lowest-index pick
    assign level_ok = (level_q < 3'(NUM_LVL));

    always_comb begin
        for (int n = 0; n < NUM_SRC; n++)
            hit[n] = level_ok && pend[n] && (route[n] == {1'b0, level_q});
        found     = 1'b0;
        found_idx = '0;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (hit[n]) begin
                found     = 1'b1;
                found_idx = SRC_W'(n);
            end
        end
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            src_q   <= '0;
            spur_q  <= 1'b0;
            cnt_q   <= '0;
        end else begin
            if (state_q == LK_IDLE && lk_start)
                level_q <= lk_level;
            if (state_q == LK_SCAN) begin
                src_q  <= found_idx;
                spur_q <= !found;
                if (!found && (cnt_q != '1))
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        lk_done     = (state_q == LK_DONE);
        lk_spurious = lk_done && spur_q;
        lk_src      = lk_done ? src_q : '0;
        spur_cnt    = cnt_q;
    end
endmodule

// File: rtl/periph_irq_router.sv
module periph_irq_router
    import pir_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 16,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [6:0]         lvl_req,
    input  logic               lk_start,
    input  logic [2:0]         lk_level,
    output logic               lk_done,
    output logic               lk_spurious,
    output logic [SRC_W-1:0]   lk_src
);
    logic [NUM_SRC-1:0][FIELD_W-1:0] route_w;
    logic [NUM_SRC-1:0]              mask_w;
    logic [NUM_SRC-1:0]              status_w;
    logic [NUM_SRC-1:0]              pend_w;
    logic [CNT_W-1:0]                spur_cnt_w;

    pir_regs #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_in(irq_in), .spur_cnt(spur_cnt_w),
        .route_o(route_w), .mask_o(mask_w), .status_o(status_w)
    );

    assign pend_w = status_w & mask_w;

    pir_level_map #(.NUM_SRC(NUM_SRC)) u_map (
        .route(route_w), .pend(pend_w), .lvl_req(lvl_req)
    );

    pir_lookup #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_lookup (
        .clk(clk), .rst_n(rst_n),
        .lk_start(lk_start), .lk_level(lk_level),
        .route(route_w), .pend(pend_w),
        .lk_done(lk_done), .lk_spurious(lk_spurious), .lk_src(lk_src),
        .spur_cnt(spur_cnt_w)
    );
endmodule

// File: rtl/pir_checker.sv
module pir_checker #(
    parameter int NUM_SRC = 32,
    parameter int CNT_W   = 16,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC-1:0] pend,
    input logic [6:0]         lvl_req,
    input logic               lk_done,
    input logic               lk_spurious,
    input logic [SRC_W-1:0]   lk_src,
    input logic [CNT_W-1:0]   spur_cnt
);
    AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> status == $past(irq_in)); // R1

    AST_LVL_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req != '0) |-> (pend != '0)); // R6

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |=> !lk_done); // R7

    AST_FOUND_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_spurious) |-> ((($past(pend)) >> lk_src) & NUM_SRC'(1)) != '0); // R7

    AST_SPUR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lk_spurious |-> lk_done); // R8

    AST_CNT_HOLD_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_spurious) |-> $stable(spur_cnt)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> spur_cnt >= $past(spur_cnt)); // R9
endmodule

bind periph_irq_router pir_checker #(.NUM_SRC(NUM_SRC), .CNT_W(CNT_W)) u_pir_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .status(status_w), .pend(pend_w),
    .lvl_req(lvl_req), .lk_done(lk_done), .lk_spurious(lk_spurious),
    .lk_src(lk_src), .spur_cnt(spur_cnt_w)
);

// File: tb/test_periph_irq_router.sv
module test_periph_irq_router;
    localparam int NSRC = 32;
    localparam int CW   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  lvl_req;
    logic        lk_start = 1'b0;
    logic [2:0]  lk_level = '0;
    logic        lk_done, lk_spurious;
    logic [4:0]  lk_src;

    int nchk = 0;
    int nerr = 0;
    int exp_cnt = 0;

    always #2 clk = ~clk;

    periph_irq_router #(.NUM_SRC(NSRC), .CNT_W(CW)) i_periph_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lvl_req(lvl_req),
        .lk_start(lk_start), .lk_level(lk_level), .lk_done(lk_done),
        .lk_spurious(lk_spurious), .lk_src(lk_src)
    );

    typedef struct packed {
        logic [31:0] irq;
        logic [31:0] mask;
        logic [6:0]  lvl;
    } vec_t;

    // routing under test: every register 0x76543210, so source n uses field n&7
    localparam vec_t VEC [8] = '{
        '{32'h0000_0001, 32'hFFFF_FFFF, 7'h01},
        '{32'h0000_0080, 32'hFFFF_FFFF, 7'h00},
        '{32'h0000_0102, 32'hFFFF_FFFF, 7'h03},
        '{32'h7F00_0000, 32'hFFFF_FFFF, 7'h7F},
        '{32'hFFFF_FFFF, 32'h0000_0000, 7'h00},
        '{32'h00F0_0000, 32'h00A0_0000, 7'h20},
        '{32'h8000_0000, 32'hFFFF_FFFF, 7'h00},
        '{32'h0000_4000, 32'hFFFF_FFFF, 7'h40}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic lookup(input logic [2:0] lvl, input logic hold,
                          output logic dn, output logic sp, output logic [4:0] s);
        @(negedge clk);
        lk_start = 1'b1; lk_level = lvl;
        @(negedge clk);
        lk_start = hold;
        @(negedge clk);
        lk_start = 1'b0;
        dn = lk_done; sp = lk_spurious; s = lk_src;
    endtask

    initial begin
        #(4 * 150000);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic dn, sp;
        logic [4:0] s;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        rd(3'd4, r); chk("R2 mask reset", r, 32'hFFFF_FFFF);
        rd(3'd0, r); chk("R2 route reset", r, 32'hFFFF_FFFF);
        rd(3'd6, r); chk("R2 count reset", r, 32'h0);
        chk("R2 lvl_req reset", {25'h0, lvl_req}, 32'h0);
        chk("R2 lk_done reset", {31'h0, lk_done}, 32'h0);

        // R3 program routing
        for (int k = 0; k < 4; k++) wr(3'(k), 32'h7654_3210);
        rd(3'd2, r); chk("R3 route readback", r, 32'h7654_3210);

        // table walk: R3 R4 R5 R6 R1
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            irq_in = VEC[i].irq;
            bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd4; bus_wdata = VEC[i].mask;
            @(negedge clk);
            bus_en = 1'b0; bus_we = 1'b0;
            chk("R6 lvl_req vector", {25'h0, lvl_req}, {25'h0, VEC[i].lvl});
            rd(3'd5, r); chk("R1 status readback", r, VEC[i].irq);
        end
        wr(3'd4, 32'hFFFF_FFFF);

        // R7 lowest pending source wins
        irq_in = 32'h0002_0202;
        lookup(3'd1, 1'b0, dn, sp, s);
        chk("R7 lookup done", {31'h0, dn}, 32'h1);
        chk("R7 lookup src", {27'h0, s}, 32'd1);
        chk("R8 no spurious on hit", {31'h0, sp}, 32'h0);
        @(negedge clk);
        chk("R7 done one cycle", {31'h0, lk_done}, 32'h0);
        wr(3'd4, 32'hFFFF_FFFD);
        lookup(3'd1, 1'b0, dn, sp, s);
        chk("R5 masked src skipped", {27'h0, s}, 32'd9);
        rd(3'd6, r); chk("R8 count unchanged on hit", r, 32'(exp_cnt));
        wr(3'd4, 32'hFFFF_FFFF);

        // R8 spurious lookup
        lookup(3'd3, 1'b0, dn, sp, s);
        exp_cnt++;
        chk("R8 spurious flag", {31'h0, sp}, 32'h1);
        rd(3'd6, r); chk("R8 count step", r, 32'(exp_cnt));

        // R4 field above 6 routes nowhere
        wr(3'd0, 32'h7654_3219);
        irq_in = 32'h0000_0001;
        @(negedge clk);
        chk("R4 field 9 no level", {25'h0, lvl_req}, 32'h0);
        lookup(3'd0, 1'b0, dn, sp, s);
        exp_cnt++;
        chk("R4 field 9 lookup spurious", {31'h0, sp}, 32'h1);
        wr(3'd0, 32'h7654_3210);

        // R10 level 7 always spurious even with a field-7 source pending
        irq_in = 32'h0000_0080;
        lookup(3'd7, 1'b0, dn, sp, s);
        exp_cnt++;
        chk("R10 level 7 spurious", {31'h0, sp}, 32'h1);

        // R10 start held while busy is ignored
        irq_in = 32'h0;
        lookup(3'd2, 1'b1, dn, sp, s);
        exp_cnt++;
        @(negedge clk);
        chk("R10 busy start ignored", {31'h0, lk_done}, 32'h0);
        @(negedge clk);
        chk("R10 still idle", {31'h0, lk_done}, 32'h0);
        rd(3'd6, r); chk("R10 single count", r, 32'(exp_cnt));

        // R10 read-only addresses and unused address
        irq_in = 32'h0000_5A5A;
        wr(3'd5, 32'h0);
        rd(3'd5, r); chk("R10 status write ignored", r, 32'h0000_5A5A);
        wr(3'd6, 32'h0);
        rd(3'd6, r); chk("R10 count write ignored", r, 32'(exp_cnt));
        rd(3'd7, r); chk("R10 addr 7 reads zero", r, 32'h0);

        // R9 saturation
        irq_in = 32'h0;
        while (exp_cnt < 16) begin
            lookup(3'd4, 1'b0, dn, sp, s);
            if (exp_cnt < 15) exp_cnt++;
            else exp_cnt = 16;
        end
        rd(3'd6, r); chk("R9 count saturates", r, 32'd15);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule